// File: doc/BRIEF.md
# Speculative Load Ordering Guard

This block is a circular load queue that allows loads to run ahead of older loads while keeping the in-order appearance that other cores rely on. Each load claims a slot at dispatch, in program order. When the load executes, its slot records the cache line it touched. The oldest slot is freed when the load retires.

A slot is exposed while its load has executed and at least one older load in the queue has not executed yet. During that window, an invalidation snoop to the recorded line means another core may have seen the two loads in swapped order. The block then issues a restart request that names the oldest exposed slot that matches. In the same edge it discards that slot and every younger one, so the pipeline can fetch again from that load. Two cases cause no action: a snoop to an unexposed slot, and a snoop to an unrelated line. The reordering stays invisible in both.

Top module: `load_order_guard`

## Requirements
- R1: After reset the queue is empty: `dispReady` is 1, `dispIdx` is 0, `flushValid` is 0, and `retAck` stays 0 even when `retReq` is 1.
- R2: A dispatch with `dispReady` high claims slot `dispIdx`, and `dispIdx` then advances by one, modulo DEPTH (default 16). After DEPTH dispatches with no retirement, `dispReady` is 0 and further dispatches have no effect.
- R3: An execute marks an allocated slot as done and records line `exeAddr[ADDR_W-1:6]`. An execute to a slot that is not allocated is ignored: a later snoop to that line does not cause a restart.
- R4: A snoop whose line equals that of an exposed slot drives `flushValid` to 1 in the next cycle, with `flushIdx` equal to that slot. A slot is exposed when it is executed and some older allocated slot is unexecuted.
- R5: A snoop that matches only slots with no unexecuted older slot causes no restart.
- R6: When several exposed slots match one snoop, `flushIdx` names the oldest of them.
- R7: A restart frees the named slot and all younger slots. In the same edge `dispIdx` moves back to `flushIdx`.
- R8: `retAck` is 1 only while `retReq` is 1, the queue is not empty, and the head slot has executed. At most one slot retires per cycle.
- R9: Lines are compared at 64-byte granularity. Addresses that differ only in bits [5:0] match.
- R10: In a cycle where a snoop causes a restart, no dispatch is accepted (`dispReady` is 0), but a retirement of the head in that same cycle still happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | A load asks for a slot |
| dispReady | output | 1 | A slot can be claimed this cycle |
| dispIdx | output | IDX_W | Slot given to the next dispatched load |
| exeValid | input | 1 | A load has executed |
| exeIdx | input | IDX_W | Slot of the executing load |
| exeAddr | input | ADDR_W | Byte address read by the executing load |
| snpValid | input | 1 | Invalidation snoop present |
| snpAddr | input | ADDR_W | Snooped byte address |
| retReq | input | 1 | Request to retire the oldest load |
| retAck | output | 1 | Oldest load retires this cycle |
| flushValid | output | 1 | Restart request, one cycle after the snoop |
| flushIdx | output | IDX_W | Slot to restart from |

## Verification
Two pairs of events can fall in one cycle and are provoked on purpose. The first pair is a restart-causing snoop and a retirement of the executed head. The second is a restart-causing snoop and a dispatch. The bench drives the snoop, the retirement request and the dispatch in the same cycle. It expects `retAck` to be high within that cycle and `dispReady` to be low. After the edge it expects the restart to name the younger slot, with `dispIdx` rewound to that slot rather than advanced. A second case places a snoop on a cycle where the head is unexecuted. There, the restart must still occur while `retAck` stays low.

// File: rtl/lqg_pkg.sv
package lqg_pkg;
  typedef struct packed {
    logic alloc;
    logic retire;
    logic flush;
  } lqStrobe_t;
endpackage

// File: rtl/lqg_entries.sv
module lqg_entries
  import lqg_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  lqStrobe_t         strobe,
  input  logic [IDX_W-1:0]  headIdx,
  input  logic [IDX_W-1:0]  tailIdx,
  input  logic              exeValid,
  input  logic [IDX_W-1:0]  exeIdx,
  input  logic [LINE_W-1:0] exeLine,
  input  logic              snpValid,
  input  logic [LINE_W-1:0] snpLine,
  output logic              hit,
  output logic [IDX_W-1:0]  hitIdx,
  output logic              headDone
);
  logic [DEPTH-1:0]  entValid;
  logic [DEPTH-1:0]  entDone;
  logic [LINE_W-1:0] entLine [DEPTH];
  logic [DEPTH-1:0]  killMask;
  logic [IDX_W-1:0]  flushOff;
  logic [IDX_W-1:0]  scanPos;
  logic              pendingSeen;

  // Age-ordered scan from the head: first executed match behind a pending load wins.
  always_comb begin
    hit         = 1'b0;
    hitIdx      = '0;
    pendingSeen = 1'b0;
    scanPos     = '0;
    for (int k = 0; k < DEPTH; k++) begin
      scanPos = headIdx + IDX_W'(k);
      if (entValid[scanPos]) begin
        if (!hit && snpValid && entDone[scanPos] && pendingSeen &&
            entLine[scanPos] == snpLine) begin
          hit    = 1'b1;
          hitIdx = scanPos;
        end
        if (!entDone[scanPos]) pendingSeen = 1'b1;
      end
    end
  end

  assign flushOff = hitIdx - headIdx;

  for (genvar g = 0; g < DEPTH; g++) begin : gKill
    logic [IDX_W-1:0] relOff;
    assign relOff      = IDX_W'(g) - headIdx;
    assign killMask[g] = strobe.flush && (relOff >= flushOff);
  end

  assign headDone = entValid[headIdx] && entDone[headIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      entDone  <= '0;
      for (int i = 0; i < DEPTH; i++) entLine[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (killMask[i]) begin
          entValid[i] <= 1'b0;
          entDone[i]  <= 1'b0;
        end else if (strobe.alloc && tailIdx == IDX_W'(i)) begin
          entValid[i] <= 1'b1;
          entDone[i]  <= 1'b0;
        end else if (strobe.retire && headIdx == IDX_W'(i)) begin
          entValid[i] <= 1'b0;
          entDone[i]  <= 1'b0;
        end else if (exeValid && exeIdx == IDX_W'(i) && entValid[i]) begin
          entDone[i]  <= 1'b1;
          entLine[i]  <= exeLine;
        end
      end
    end
  end
endmodule

// File: rtl/lqg_ctrl.sv
module lqg_ctrl
  import lqg_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic             retReq,
  input  logic             hit,
  input  logic [IDX_W-1:0] hitIdx,
  input  logic             headDone,
  output lqStrobe_t        strobe,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] tailIdx,
  output logic             dispReady,
  output logic             retAck,
  output logic             flushValid,
  output logic [IDX_W-1:0] flushIdx
);
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;
  logic [PTR_W-1:0] used;
  logic             isFull;
  logic             isEmpty;

  assign used    = tailPtr - headPtr;
  assign isFull  = used == PTR_W'(DEPTH);
  assign isEmpty = used == '0;
  assign headIdx = headPtr[IDX_W-1:0];
  assign tailIdx = tailPtr[IDX_W-1:0];

  assign strobe.flush  = hit;
  assign strobe.alloc  = dispValid && !isFull && !hit;
  assign strobe.retire = retReq && !isEmpty && headDone;

  assign dispReady = !isFull && !hit;
  assign retAck    = strobe.retire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr    <= '0;
      tailPtr    <= '0;
      flushValid <= 1'b0;
      flushIdx   <= '0;
    end else begin
      if (strobe.retire) headPtr <= headPtr + 1'b1;
      if (strobe.flush)
        tailPtr <= headPtr + {1'b0, IDX_W'(hitIdx - headIdx)};
      else if (strobe.alloc)
        tailPtr <= tailPtr + 1'b1;
      flushValid <= hit;
      if (hit) flushIdx <= hitIdx;
    end
  end
endmodule

// File: rtl/load_order_guard.sv
module load_order_guard
  import lqg_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int LINE_LSB  = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - LINE_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dispValid,
  output logic              dispReady,
  output logic [IDX_W-1:0]  dispIdx,
  input  logic              exeValid,
  input  logic [IDX_W-1:0]  exeIdx,
  input  logic [ADDR_W-1:0] exeAddr,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic              retReq,
  output logic              retAck,
  output logic              flushValid,
  output logic [IDX_W-1:0]  flushIdx
);
  lqStrobe_t        strobe;
  logic             hit;
  logic [IDX_W-1:0] hitIdx;
  logic             headDone;
  logic [IDX_W-1:0] headIdx;
  logic [IDX_W-1:0] tailIdx;

  lqg_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .retReq(retReq),
    .hit(hit), .hitIdx(hitIdx), .headDone(headDone), .strobe(strobe),
    .headIdx(headIdx), .tailIdx(tailIdx), .dispReady(dispReady),
    .retAck(retAck), .flushValid(flushValid), .flushIdx(flushIdx)
  );

  lqg_entries #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LINE_W(LINE_W)) uEnt (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headIdx(headIdx),
    .tailIdx(tailIdx), .exeValid(exeValid), .exeIdx(exeIdx),
    .exeLine(exeAddr[ADDR_W-1:LINE_LSB]), .snpValid(snpValid),
    .snpLine(snpAddr[ADDR_W-1:LINE_LSB]), .hit(hit), .hitIdx(hitIdx),
    .headDone(headDone)
  );

  assign dispIdx = tailIdx;
endmodule

// File: rtl/lqg_checker.sv
module lqg_checker #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             dispValid,
  input logic             dispReady,
  input logic [IDX_W-1:0] dispIdx,
  input logic             snpValid,
  input logic             retReq,
  input logic             retAck,
  input logic             flushValid,
  input logic [IDX_W-1:0] flushIdx
);
  // R7
  rewind_to_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> dispIdx == flushIdx);

  // R8
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    retAck |-> retReq);

  // R2
  disp_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && dispReady) |=> dispIdx == IDX_W'($past(dispIdx) + 1'b1));

  // R2
  tail_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dispValid && dispReady) |=> ($stable(dispIdx) || flushValid));

  // R4
  flush_needs_snoop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !snpValid |=> !flushValid);
endmodule

bind load_order_guard lqg_checker #(.IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispReady(dispReady),
  .dispIdx(dispIdx), .snpValid(snpValid), .retReq(retReq), .retAck(retAck),
  .flushValid(flushValid), .flushIdx(flushIdx)
);

// File: tb/sim_load_order_guard.sv
module sim_load_order_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 31;

  typedef struct packed {
    logic        disp;
    logic        exe;
    logic [3:0]  exeIdx;
    logic [31:0] exeAddr;
    logic        snp;
    logic [31:0] snpAddr;
    logic        ret;
    logic        expAck;
    logic        expFlush;
    logic [3:0]  expFlushIdx;
    logic [3:0]  expDispIdx;
    logic [3:0]  req;
  } vec_t;

  // disp exe idx addr snp addr ret | ack flush fidx didx req
  localparam vec_t VEC [NVEC] = '{
    '{1'b1,1'b0,4'd0,32'h0,    1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd0,4'd1,4'd2},  // R2
    '{1'b1,1'b0,4'd0,32'h0,    1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd0,4'd2,4'd2},  // R2
    '{1'b1,1'b0,4'd0,32'h0,    1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd0,4'd3,4'd2},  // R2
    '{1'b0,1'b1,4'd2,32'h1000, 1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd0,4'd3,4'd3},  // R3
    '{1'b0,1'b0,4'd0,32'h0,    1'b1,32'h1000, 1'b0, 1'b0,1'b1,4'd2,4'd2,4'd4},  // R4
    '{1'b0,1'b0,4'd0,32'h0,    1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd2,4'd2,4'd7},  // R7
    '{1'b1,1'b0,4'd0,32'h0,    1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd2,4'd3,4'd7},  // R7
    '{1'b0,1'b1,4'd0,32'h2000, 1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd2,4'd3,4'd3},  // R3
    '{1'b0,1'b1,4'd1,32'h3000, 1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd2,4'd3,4'd3},  // R3
    '{1'b0,1'b0,4'd0,32'h0,    1'b1,32'h2000, 1'b0, 1'b0,1'b0,4'd2,4'd3,4'd5},  // R5
    '{1'b0,1'b0,4'd0,32'h0,    1'b1,32'h3000, 1'b0, 1'b0,1'b0,4'd2,4'd3,4'd5},  // R5
    '{1'b0,1'b0,4'd0,32'h0,    1'b0,32'h0,    1'b1, 1'b1,1'b0,4'd2,4'd3,4'd8},  // R8
    '{1'b0,1'b0,4'd0,32'h0,    1'b0,32'h0,    1'b1, 1'b1,1'b0,4'd2,4'd3,4'd8},  // R8
    '{1'b0,1'b0,4'd0,32'h0,    1'b0,32'h0,    1'b1, 1'b0,1'b0,4'd2,4'd3,4'd8},  // R8
    '{1'b1,1'b0,4'd0,32'h0,    1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd2,4'd4,4'd2},  // R2
    '{1'b0,1'b1,4'd3,32'h4000, 1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd2,4'd4,4'd3},  // R3
    '{1'b0,1'b0,4'd0,32'h0,    1'b1,32'h403F, 1'b0, 1'b0,1'b1,4'd3,4'd3,4'd9},  // R9
    '{1'b0,1'b0,4'd0,32'h0,    1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd3,4'd3,4'd7},  // R7
    '{1'b1,1'b0,4'd0,32'h0,    1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd3,4'd4,4'd2},  // R2
    '{1'b1,1'b0,4'd0,32'h0,    1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd3,4'd5,4'd2},  // R2
    '{1'b0,1'b1,4'd4,32'h5000, 1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd3,4'd5,4'd3},  // R3
    '{1'b0,1'b1,4'd3,32'h5004, 1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd3,4'd5,4'd3},  // R3
    '{1'b0,1'b0,4'd0,32'h0,    1'b1,32'h5000, 1'b1, 1'b0,1'b1,4'd3,4'd3,4'd6},  // R6
    '{1'b0,1'b1,4'd2,32'h6000, 1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd3,4'd3,4'd3},  // R3
    '{1'b1,1'b0,4'd0,32'h0,    1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd3,4'd4,4'd2},  // R2
    '{1'b1,1'b0,4'd0,32'h0,    1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd3,4'd5,4'd2},  // R2
    '{1'b0,1'b1,4'd4,32'h7000, 1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd3,4'd5,4'd3},  // R3
    '{1'b1,1'b0,4'd0,32'h0,    1'b1,32'h7000, 1'b1, 1'b1,1'b1,4'd4,4'd4,4'd10}, // R10
    '{1'b0,1'b0,4'd0,32'h0,    1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd4,4'd4,4'd7},  // R7
    '{1'b0,1'b1,4'd9,32'h8000, 1'b0,32'h0,    1'b0, 1'b0,1'b0,4'd4,4'd4,4'd3},  // R3
    '{1'b0,1'b0,4'd0,32'h0,    1'b1,32'h8000, 1'b0, 1'b0,1'b0,4'd4,4'd4,4'd3}   // R3
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dispValid = 1'b0;
  logic        dispReady;
  logic [3:0]  dispIdx;
  logic        exeValid = 1'b0;
  logic [3:0]  exeIdx = '0;
  logic [31:0] exeAddr = '0;
  logic        snpValid = 1'b0;
  logic [31:0] snpAddr = '0;
  logic        retReq = 1'b0;
  logic        retAck;
  logic        flushValid;
  logic [3:0]  flushIdx;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_order_guard u0 (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispReady(dispReady),
    .dispIdx(dispIdx), .exeValid(exeValid), .exeIdx(exeIdx), .exeAddr(exeAddr),
    .snpValid(snpValid), .snpAddr(snpAddr), .retReq(retReq), .retAck(retAck),
    .flushValid(flushValid), .flushIdx(flushIdx)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    dispValid = 1'b0; exeValid = 1'b0; snpValid = 1'b0; retReq = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: empty after reset, retire request refused
    retReq = 1'b1;
    #1;
    check("R1", "dispReady", int'(dispReady), 1);
    check("R1", "dispIdx", int'(dispIdx), 0);
    check("R1", "flushValid", int'(flushValid), 0);
    check("R1", "retAck", int'(retAck), 0);
    retReq = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      dispValid = VEC[v].disp;
      exeValid  = VEC[v].exe;
      exeIdx    = VEC[v].exeIdx;
      exeAddr   = VEC[v].exeAddr;
      snpValid  = VEC[v].snp;
      snpAddr   = VEC[v].snpAddr;
      retReq    = VEC[v].ret;
      #1;
      check($sformatf("R%0d", VEC[v].req), "retAck", int'(retAck), int'(VEC[v].expAck));
      if (VEC[v].req == 4'd10)
        check("R10", "dispReady during restart", int'(dispReady), 0);
      @(posedge clk);
      @(negedge clk);
      idleInputs();
      check($sformatf("R%0d", VEC[v].req), "flushValid", int'(flushValid), int'(VEC[v].expFlush));
      if (VEC[v].expFlush)
        check($sformatf("R%0d", VEC[v].req), "flushIdx", int'(flushIdx), int'(VEC[v].expFlushIdx));
      check($sformatf("R%0d", VEC[v].req), "dispIdx", int'(dispIdx), int'(VEC[v].expDispIdx));
    end

    // R2: fill from empty, then a further dispatch is refused
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int n = 0; n < 16; n++) begin
      dispValid = 1'b1;
      @(negedge clk);
    end
    dispValid = 1'b0;
    check("R2", "dispReady when full", int'(dispReady), 0);
    check("R2", "dispIdx wrapped", int'(dispIdx), 0);
    dispValid = 1'b1;
    @(negedge clk);
    dispValid = 1'b0;
    check("R2", "dispIdx after refused dispatch", int'(dispIdx), 0);

    // R8: head executes, one retirement, next head unexecuted
    exeValid = 1'b1; exeIdx = 4'd0; exeAddr = 32'h9000;
    @(negedge clk);
    exeValid = 1'b0;
    retReq = 1'b1;
    #1;
    check("R8", "retAck head done", int'(retAck), 1);
    @(negedge clk);
    #1;
    check("R8", "retAck next head pending", int'(retAck), 0);
    check("R2", "dispReady after retire", int'(dispReady), 1);
    retReq = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule